// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back pieces of a pool of 2^POOL_LG equal minimum-size units. Every piece is a power-of-two number of units, named by its order k (2^k units), and always starts at an address that is a multiple of its own size. The free state is held in registers as one bitmap per order. Each bitmap has one bit for every aligned position that a piece of that order could take.

An allocate request names an order. The block takes the smallest free piece whose order is at least the requested one, choosing the lowest address at that order. It then cuts that piece in halves, one order per cycle, until it reaches the requested order. It keeps the lower half each time and marks the upper half free. A free request names an address and an order. The block walks upward one order per cycle. At each step it joins the piece with its partner when the partner is free. The partner's address is the piece's address with bit k inverted. The walk ends at the first order whose partner is busy, or when the whole pool has been rebuilt.

Requests use a busy/done handshake and are handled one at a time. A request is taken only while `busy` is low. The result appears on a one-cycle `done` pulse.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, only the whole pool (order POOL_LG, address 0) is free, `busy` is 0 and `done` is 0.
- R2: A successful allocate of order r returns the lowest address among the free pieces of the smallest order k >= r that has any free piece. The returned address is a multiple of 2^r and `resp_ok` is 1.
- R3: When k > r, the block splits the piece one order per cycle. It keeps the lower half and marks the upper half free at each order from k-1 down to r. `done` rises k-r+2 cycles after the accepting clock edge.
- R4: An allocate whose order exceeds POOL_LG, or for which no free piece of order r or above exists, gives `done` with `resp_ok`=0 and `resp_err`=0 one cycle after acceptance. The free state is left unchanged.
- R5: A free of order k at address a checks whether the partner at a with bit k inverted is free at order k. If it is, the two join into the piece of order k+1 at the lower address, and the check repeats at the next order.
- R6: A free that performs m joins gives `done` with `resp_ok`=1 and `resp_err`=0, m+2 cycles after acceptance.
- R7: A free of a piece whose bit at its own order is already set is ignored: the free state is left unchanged, and `done` comes one cycle after acceptance with `resp_ok`=0 and `resp_err`=1.
- R8: A free whose order exceeds POOL_LG, or whose address is not a multiple of 2^order, is rejected the same way as R7.
- R9: `busy` is 1 from the cycle after acceptance until the cycle `done` is 1, and is 0 in that cycle. A `req_valid` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| req_free | input | 1 | 1 = free request, 0 = allocate request |
| req_order | input | OW ($clog2(POOL_LG+1)) | Piece size as order (2^order units) |
| req_addr | input | POOL_LG | Piece address for a free request |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| resp_ok | output | 1 | Request succeeded |
| resp_addr | output | POOL_LG | Allocated address (valid with `done` and `resp_ok` on an allocate) |
| resp_err | output | 1 | Free rejected: double free or malformed |

## Verification
The assertions assume that a free names a piece that the caller really holds, or one that is free at exactly the named order. They assume it never names a piece that lies inside a larger free piece, because the per-order bitmap cannot see that case. Under this assumption, a set never hits a set bit and a clear never hits a clear bit. The bench keeps within this rule: random frees come only from a list of pieces it has been granted, and the directed double frees repeat a free that did not join with its partner. Requests sent while the block is busy are made deliberately malformed, so that acting on one by mistake would show up in the response or in later grants.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_MERGE = 2'd2
  } buddy_state_e;

  function automatic int ord_width(input int pool_lg);
    return (pool_lg < 1) ? 1 : $clog2(pool_lg + 1);
  endfunction

endpackage

// File: rtl/buddy_map.sv
module buddy_map #(
  parameter int AW = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [buddy_pkg::ord_width(AW)-1:0] set_ord,
  input  logic [AW-1:0]                  set_idx,
  input  logic                           clr_en,
  input  logic [buddy_pkg::ord_width(AW)-1:0] clr_ord,
  input  logic [AW-1:0]                  clr_idx,
  output logic [AW:0][(1<<AW)-1:0]       map_o
);
  localparam int NORD = AW + 1;
  localparam int NU   = 1 << AW;

  logic [NORD-1:0][NU-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (clr_en) map_d[clr_ord][clr_idx] = 1'b0;
    if (set_en) map_d[set_ord][set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q        <= '0;
      map_q[AW][0] <= 1'b1;
    end else if (set_en || clr_en) begin
      map_q <= map_d;
    end
  end

  assign map_o = map_q;

  // R3 R5
  set_clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !map_q[set_ord][set_idx]);

  // R2 R5
  clr_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> map_q[clr_ord][clr_idx]);

endmodule

// File: rtl/buddy_search.sv
module buddy_search #(
  parameter int AW = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [AW:0][(1<<AW)-1:0]            map_i,
  input  logic [buddy_pkg::ord_width(AW)-1:0] want_ord,
  output logic                                found,
  output logic [buddy_pkg::ord_width(AW)-1:0] f_ord,
  output logic [AW-1:0]                       f_idx
);
  localparam int OW = buddy_pkg::ord_width(AW);
  localparam int NU = 1 << AW;

  logic [NU-1:0] row;

  always_comb begin
    found = 1'b0;
    f_ord = '0;
    for (int k = AW; k >= 0; k--) begin
      if (k >= int'(want_ord) && (|map_i[k])) begin
        found = 1'b1;
        f_ord = OW'(k);
      end
    end
  end

  assign row = map_i[f_ord];

  always_comb begin
    f_idx = '0;
    for (int i = NU - 1; i >= 0; i--) begin
      if (row[i]) f_idx = AW'(i);
    end
  end

  // R2
  found_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (map_i[f_ord][f_idx] && f_ord >= want_ord));

endmodule

// File: rtl/buddy_fsm.sv
module buddy_fsm #(
  parameter int AW = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic                                req_free,
  input  logic [buddy_pkg::ord_width(AW)-1:0] req_order,
  input  logic [AW-1:0]                       req_addr,
  input  logic [AW:0][(1<<AW)-1:0]            map_i,
  input  logic                                found,
  input  logic [buddy_pkg::ord_width(AW)-1:0] f_ord,
  input  logic [AW-1:0]                       f_idx,
  output logic                                set_en,
  output logic [buddy_pkg::ord_width(AW)-1:0] set_ord,
  output logic [AW-1:0]                       set_idx,
  output logic                                clr_en,
  output logic [buddy_pkg::ord_width(AW)-1:0] clr_ord,
  output logic [AW-1:0]                       clr_idx,
  output logic                                busy,
  output logic                                done,
  output logic                                resp_ok,
  output logic [AW-1:0]                       resp_addr,
  output logic                                resp_err
);
  import buddy_pkg::*;
  localparam int OW = ord_width(AW);
  localparam logic [OW-1:0] MAXO = OW'(AW);

  buddy_state_e   state_q, state_d;
  logic [OW-1:0]  cur_ord_q, cur_ord_d;
  logic [AW-1:0]  cur_addr_q, cur_addr_d;
  logic [OW-1:0]  tgt_q, tgt_d;
  logic           done_q, done_d;
  logic           ok_q, ok_d;
  logic           err_q, err_d;
  logic [AW-1:0]  raddr_q, raddr_d;

  logic           accept;
  logic           bad_free;
  logic [AW-1:0]  req_idx;
  logic [AW-1:0]  mate_idx;
  logic [AW-1:0]  low_mask;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign low_mask = (AW'(1) << req_order) - AW'(1);
  assign req_idx  = req_addr >> req_order;
  assign bad_free = (req_order > MAXO) || ((req_addr & low_mask) != '0);
  assign mate_idx = (cur_addr_q >> cur_ord_q) ^ AW'(1);

  always_comb begin
    state_d    = state_q;
    cur_ord_d  = cur_ord_q;
    cur_addr_d = cur_addr_q;
    tgt_d      = tgt_q;
    done_d     = 1'b0;
    ok_d       = ok_q;
    err_d      = 1'b0;
    raddr_d    = raddr_q;
    set_en     = 1'b0;
    set_ord    = '0;
    set_idx    = '0;
    clr_en     = 1'b0;
    clr_ord    = '0;
    clr_idx    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tgt_d = req_order;
          if (!req_free) begin
            if (req_order > MAXO || !found) begin
              done_d = 1'b1;
              ok_d   = 1'b0;
            end else begin
              clr_en     = 1'b1;
              clr_ord    = f_ord;
              clr_idx    = f_idx;
              cur_ord_d  = f_ord;
              cur_addr_d = f_idx << f_ord;
              state_d    = ST_SPLIT;
            end
          end else begin
            if (bad_free || map_i[req_order][req_idx]) begin
              done_d = 1'b1;
              ok_d   = 1'b0;
              err_d  = 1'b1;
            end else begin
              cur_ord_d  = req_order;
              cur_addr_d = req_addr;
              state_d    = ST_MERGE;
            end
          end
        end
      end
      ST_SPLIT: begin
        if (cur_ord_q == tgt_q) begin
          done_d  = 1'b1;
          ok_d    = 1'b1;
          raddr_d = cur_addr_q;
          state_d = ST_IDLE;
        end else begin
          set_en    = 1'b1;
          set_ord   = cur_ord_q - OW'(1);
          set_idx   = (cur_addr_q >> (cur_ord_q - OW'(1))) | AW'(1);
          cur_ord_d = cur_ord_q - OW'(1);
        end
      end
      ST_MERGE: begin
        if (cur_ord_q < MAXO && map_i[cur_ord_q][mate_idx]) begin
          clr_en     = 1'b1;
          clr_ord    = cur_ord_q;
          clr_idx    = mate_idx;
          cur_addr_d = cur_addr_q & ~(AW'(1) << cur_ord_q);
          cur_ord_d  = cur_ord_q + OW'(1);
        end else begin
          set_en  = 1'b1;
          set_ord = cur_ord_q;
          set_idx = cur_addr_q >> cur_ord_q;
          done_d  = 1'b1;
          ok_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_ord_q  <= '0;
      cur_addr_q <= '0;
      tgt_q      <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      err_q      <= 1'b0;
      raddr_q    <= '0;
    end else begin
      state_q    <= state_d;
      cur_ord_q  <= cur_ord_d;
      cur_addr_q <= cur_addr_d;
      tgt_q      <= tgt_d;
      done_q     <= done_d;
      ok_q       <= ok_d;
      err_q      <= err_d;
      raddr_q    <= raddr_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign resp_ok   = ok_q;
  assign resp_err  = err_q;
  assign resp_addr = raddr_q;

  // R3
  split_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPLIT) |-> (cur_ord_q >= tgt_q && cur_ord_q <= MAXO));

  // R5
  merge_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MERGE) |-> (cur_ord_q <= MAXO));

  // R2
  grant_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ok_q && $past(state_q == ST_SPLIT)) |->
      ((resp_addr & ((AW'(1) << tgt_q) - AW'(1))) == '0));

  // R7 R8
  err_means_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (done_q && !ok_q));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter int POOL_LG = 4,
  localparam int OW = buddy_pkg::ord_width(POOL_LG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_free,
  input  logic [OW-1:0]      req_order,
  input  logic [POOL_LG-1:0] req_addr,
  output logic               busy,
  output logic               done,
  output logic               resp_ok,
  output logic [POOL_LG-1:0] resp_addr,
  output logic               resp_err
);
  localparam int AW = POOL_LG;
  localparam int NU = 1 << AW;

  logic [AW:0][NU-1:0] map_w;
  logic                found_w;
  logic [OW-1:0]       f_ord_w;
  logic [AW-1:0]       f_idx_w;
  logic                set_en_w, clr_en_w;
  logic [OW-1:0]       set_ord_w, clr_ord_w;
  logic [AW-1:0]       set_idx_w, clr_idx_w;

  buddy_map #(.AW(AW)) i_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en_w), .set_ord(set_ord_w), .set_idx(set_idx_w),
    .clr_en(clr_en_w), .clr_ord(clr_ord_w), .clr_idx(clr_idx_w),
    .map_o(map_w)
  );

  buddy_search #(.AW(AW)) i_search (
    .clk(clk), .rst_n(rst_n),
    .map_i(map_w), .want_ord(req_order),
    .found(found_w), .f_ord(f_ord_w), .f_idx(f_idx_w)
  );

  buddy_fsm #(.AW(AW)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_free(req_free),
    .req_order(req_order), .req_addr(req_addr),
    .map_i(map_w), .found(found_w), .f_ord(f_ord_w), .f_idx(f_idx_w),
    .set_en(set_en_w), .set_ord(set_ord_w), .set_idx(set_idx_w),
    .clr_en(clr_en_w), .clr_ord(clr_ord_w), .clr_idx(clr_idx_w),
    .busy(busy), .done(done), .resp_ok(resp_ok),
    .resp_addr(resp_addr), .resp_err(resp_err)
  );

endmodule

// File: tb/test_buddy_alloc.sv
`timescale 1ns/1ps
module test_buddy_alloc;
  localparam int AW = 4;
  localparam int OW = buddy_pkg::ord_width(AW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_free = 1'b0;
  logic [OW-1:0] req_order = '0;
  logic [AW-1:0] req_addr = '0;
  logic busy, done, resp_ok, resp_err;
  logic [AW-1:0] resp_addr;

  int checks = 0, errors = 0;
  int fq[$];      // free pieces: (order << 8) | addr
  int held[$];    // granted pieces: (order << 8) | addr

  always #5 clk = ~clk;

  buddy_alloc #(.POOL_LG(AW)) i_buddy_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_order(req_order), .req_addr(req_addr), .busy(busy), .done(done),
    .resp_ok(resp_ok), .resp_addr(resp_addr), .resp_err(resp_err)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int find_free(input int o, input int a);
    foreach (fq[i]) if (fq[i] == ((o << 8) | a)) return i;
    return -1;
  endfunction

  function automatic void model_alloc(input int r, output bit ok, output int a, output int lat);
    int best;
    int bo, ba, o;
    best = -1; bo = 99; ba = 0; ok = 0; a = 0; lat = 1;
    if (r > AW) return;
    foreach (fq[i]) begin
      int fo, fa;
      fo = fq[i] >> 8; fa = fq[i] & 255;
      if (fo >= r && (fo < bo || (fo == bo && fa < ba))) begin
        best = i; bo = fo; ba = fa;
      end
    end
    if (best < 0) return;
    fq.delete(best);
    o = bo;
    while (o > r) begin
      o--;
      fq.push_back((o << 8) | (ba + (1 << o)));
    end
    ok = 1; a = ba; lat = bo - r + 2;
  endfunction

  function automatic void model_free(input int o, input int a, output bit ok, output bit err, output int lat);
    int m, j;
    ok = 0; err = 1; lat = 1;
    if (o > AW) return;
    if ((a % (1 << o)) != 0) return;
    if (find_free(o, a) >= 0) return;
    m = 0;
    forever begin
      if (o >= AW) break;
      j = find_free(o, a ^ (1 << o));
      if (j < 0) break;
      fq.delete(j);
      a = a & ~(1 << o);
      o++; m++;
    end
    fq.push_back((o << 8) | a);
    ok = 1; err = 0; lat = m + 2;
  endfunction

  // Drive one request, then compare the ports on every clock until done.
  task automatic run(input bit fr, input int o, input int a, input bit exp_ok,
                     input int exp_addr, input bit exp_err, input int lat,
                     input bit poke, input string req);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_order = OW'(o); req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      chk(busy == 1'b1, "R9 busy while working", int'(busy), 1);
      if (poke && n == 1) begin
        req_valid = 1'b1; req_free = 1'b1; req_order = OW'(AW + 1); req_addr = '0;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    chk(n == lat, {req, " done latency"}, n, lat);
    chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    chk(resp_ok == exp_ok, {req, " resp_ok"}, int'(resp_ok), int'(exp_ok));
    chk(resp_err == exp_err, {req, " resp_err"}, int'(resp_err), int'(exp_err));
    if (!fr && exp_ok) chk(int'(resp_addr) == exp_addr, {req, " resp_addr"}, int'(resp_addr), exp_addr);
    @(negedge clk);
    chk(done == 1'b0, "R9 done is one pulse", int'(done), 0);
  endtask

  task automatic do_alloc(input int r, input bit poke, input string req);
    bit ok; int a, lat;
    model_alloc(r, ok, a, lat);
    run(1'b0, r, 0, ok, a, 1'b0, lat, poke, req);
    if (ok) held.push_back((r << 8) | a);
  endtask

  task automatic do_free(input int o, input int a, input string req);
    bit ok, err; int lat;
    model_free(o, a, ok, err, lat);
    run(1'b1, o, a, ok, 0, err, lat, 1'b0, req);
    foreach (held[i]) if (held[i] == ((o << 8) | a)) begin held.delete(i); break; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fq.push_back((AW << 8) | 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 split from order 4 down to 0; R9 request while busy is ignored
    do_alloc(0, 1'b1, "R3");
    do_alloc(1, 1'b0, "R2");           // upper half at 2
    do_alloc(3, 1'b0, "R2");           // 8
    do_alloc(3, 1'b0, "R4");           // nothing left at order 3+
    do_alloc(2, 1'b0, "R2");           // 4
    do_alloc(0, 1'b0, "R3");           // 1
    do_alloc(0, 1'b0, "R4");           // pool exhausted
    do_alloc(AW + 1, 1'b0, "R4");      // order too big
    do_free(0, 1, "R6");               // partner busy, no join
    do_free(0, 1, "R7");               // double free
    do_free(0, 0, "R5");               // join to order 1
    do_free(1, 2, "R5");               // join to order 2
    do_free(2, 4, "R5");               // join to order 3
    do_free(3, 8, "R5");               // join to whole pool
    do_free(2, 2, "R8");               // misaligned
    do_free(AW + 1, 0, "R8");          // order too big
    do_alloc(AW, 1'b0, "R1");          // whole pool back again
    do_free(AW, 0, "R6");
    for (int it = 0; it < 300; it++) begin
      if (held.size() > 0 && ($urandom % 2) == 1) begin
        int k, e;
        k = $urandom % held.size();
        e = held[k];
        do_free(e >> 8, e & 255, "R5");
      end else begin
        do_alloc($urandom % (AW + 2), 1'b0, "R2");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule